// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Sequencer

This block sits between a clocked system bus and an asynchronous static memory that holds 128K words of 8 bits. A host offers one access at a time with a valid/ready handshake carrying an address, a write flag and a write byte. The sequencer then produces the active-low chip-select, output-enable and write-strobe lines. It drives the address and controls an 8-bit data path. That path is split into an output value, an output-enable and an input value, so the pad-level tri-state buffer stays outside the block.

Every access runs through phases whose lengths are whole clock cycles, set by parameters: address setup, read access, write-strobe width, data setup, data hold and the memory's output float time. A read returns its byte with a one-cycle valid pulse. A write can keep output-enable low for its whole strobe. In that case the data driver waits out the memory's float time, so the two never fight over the bus. After each access one or more cycles pass with every strobe high before the next access can start.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip-select, output-enable and write-strobe are all high (1), the data driver is off, request-ready is high and read-valid is low.
- R2: Request-ready goes low in the cycle after an access is accepted. It stays low until the access is over. A read is over ASU+RD+2 cycles after acceptance. A write is over ASU+WLEN+DH+2 cycles after acceptance.
- R3: The address is valid for at least ASU cycles before chip-select falls. It does not change while chip-select is low.
- R4: A read keeps chip-select and output-enable low with write-strobe high for RD cycles. The byte on the data input is captured at the clock edge that closes that window. Read-valid is a single-cycle pulse, first seen ASU+RD+1 cycles after acceptance, and carries the captured byte.
- R5: A write keeps chip-select and write-strobe low together for WLEN cycles, where WLEN = max(WEP, WZ+DSU). WZ equals the float-time parameter when output-enable is kept low during writes, and 0 otherwise. Chip-select and write-strobe rise on the same edge.
- R6: When output-enable is kept low during writes, output-enable is low for the whole strobe. The data driver stays off for the first WZ cycles after write-strobe falls, so it is never on while the memory still drives the bus.
- R7: The write byte is driven for at least DSU cycles before write-strobe rises. It is held unchanged for at least DH cycles after the rise. A later read of that address returns it.
- R8: Between the end of one access and the fall of chip-select for the next, there is at least one cycle with all strobes high and the driver off. The driver is only released while all strobes are high.
- R9: Write-strobe is never low while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Sequencer idle; request accepted on valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Captured read byte |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_ce_n | output | 1 | Chip-select, active low |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_we_n | output | 1 | Write-strobe, active low |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the data driver, active high |
| sram_dq_in | input | DATA_W | Data from the bus |

## Verification
The bench goes after the write with output-enable held low, where the bus changes hands. A sequencer that turned its driver on as the strobe fell would collide with a model memory that keeps driving for the float time. One that dropped the driver with the strobe would store a byte with no hold time. Every address of a small configuration is written and read back with two patterns, and the requests are issued back to back. An off-by-one phase count therefore shows up as a wrong latency, a missing idle gap between accesses, or a read captured before the model drives the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RACC  = 3'd2,
    ST_WLOW  = 3'd3,
    ST_WHOLD = 3'd4,
    ST_TURN  = 3'd5
  } seq_state_t;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [ADDR_W-1:0] hold_addr,
  output logic              hold_write,
  output logic [DATA_W-1:0] hold_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr  <= '0;
      hold_write <= 1'b0;
      hold_wdata <= '0;
    end else if (accept) begin
      hold_addr  <= in_addr;
      hold_write <= in_write;
      hold_wdata <= in_wdata;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] bus_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= bus_in;
    end
  end

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ASU_CYC   = 1,
  parameter int WEP_CYC   = 3,
  parameter int DSU_CYC   = 2,
  parameter int DH_CYC    = 1,
  parameter int RD_CYC    = 3,
  parameter int WZ_CYC    = 2,
  parameter bit WR_OE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic is_write,
  output logic accept,
  output logic ready,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe,
  output logic cap
);

  localparam int ASU    = at_least_one(ASU_CYC);
  localparam int WEP    = at_least_one(WEP_CYC);
  localparam int DSU    = at_least_one(DSU_CYC);
  localparam int DH     = at_least_one(DH_CYC);
  localparam int RD     = at_least_one(RD_CYC);
  localparam int WZ     = WR_OE_LOW ? ((WZ_CYC < 0) ? 0 : WZ_CYC) : 0;
  localparam int WLEN   = imax(WEP, WZ + DSU);
  localparam int MAXLEN = imax(imax(ASU, WLEN), imax(DH, RD));
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  seq_state_t       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] phase_last;
  logic             at_last;
  logic             drv_gate;

  assign accept = req_valid && ready;

  always_comb begin
    unique case (st)
      ST_SETUP: phase_last = CNT_W'(ASU - 1);
      ST_RACC:  phase_last = CNT_W'(RD - 1);
      ST_WLOW:  phase_last = CNT_W'(WLEN - 1);
      ST_WHOLD: phase_last = CNT_W'(DH - 1);
      default:  phase_last = '0;
    endcase
  end

  assign at_last = (cnt == phase_last);
  assign cap     = (st == ST_RACC) && at_last;

  always_comb begin
    st_n  = st;
    cnt_n = cnt + 1'b1;
    if (at_last) cnt_n = '0;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (accept) st_n = ST_SETUP;
      end
      ST_SETUP: if (at_last) st_n = is_write ? ST_WLOW : ST_RACC;
      ST_RACC:  if (at_last) st_n = ST_TURN;
      ST_WLOW:  if (at_last) st_n = ST_WHOLD;
      ST_WHOLD: if (at_last) st_n = ST_TURN;
      ST_TURN: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  generate
    if (WZ == 0) begin : g_drive_now
      assign drv_gate = 1'b1;
    end else begin : g_drive_wait
      assign drv_gate = (cnt_n >= CNT_W'(WZ));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      ready <= 1'b1;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      ready <= (st_n == ST_IDLE);
      ce_n  <= !(st_n == ST_RACC || st_n == ST_WLOW);
      we_n  <= !(st_n == ST_WLOW);
      oe_n  <= !(st_n == ST_RACC || (WR_OE_LOW && st_n == ST_WLOW));
      dq_oe <= (st_n == ST_WLOW && drv_gate) || (st_n == ST_WHOLD);
    end
  end

  // R9
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);

  // R5
  ce_we_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> $rose(ce_n));

  // R8
  drv_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe) |-> (ce_n && we_n && oe_n));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n || dq_oe) |-> !ready);

  generate
    if (WZ > 0) begin : g_float_chk
      // R6
      early_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> (!dq_oe && !oe_n));
    end
  endgenerate

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int ASU_CYC   = 1,
  parameter int WEP_CYC   = 3,
  parameter int DSU_CYC   = 2,
  parameter int DH_CYC    = 1,
  parameter int RD_CYC    = 3,
  parameter int WZ_CYC    = 2,
  parameter bit WR_OE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  logic accept;
  logic hold_write;
  logic cap;

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .in_addr    (req_addr),
    .in_write   (req_write),
    .in_wdata   (req_wdata),
    .hold_addr  (sram_addr),
    .hold_write (hold_write),
    .hold_wdata (sram_dq_out)
  );

  sram_seq_fsm #(
    .ASU_CYC(ASU_CYC), .WEP_CYC(WEP_CYC), .DSU_CYC(DSU_CYC), .DH_CYC(DH_CYC),
    .RD_CYC(RD_CYC), .WZ_CYC(WZ_CYC), .WR_OE_LOW(WR_OE_LOW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .is_write  (hold_write),
    .accept    (accept),
    .ready     (req_ready),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe),
    .cap       (cap)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .bus_in   (sram_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int ASU  = 2;
  localparam int WEP  = 2;
  localparam int DSU  = 2;
  localparam int DH   = 1;
  localparam int RD   = 3;
  localparam int WZ   = 2;
  localparam int WLEN = (WEP > WZ + DSU) ? WEP : WZ + DSU;
  localparam int NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out, sram_dq_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] mem [NW];
  int  we_low_cnt = 0;
  logic mem_drv;

  always #2 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ASU_CYC(ASU), .WEP_CYC(WEP), .DSU_CYC(DSU),
    .DH_CYC(DH), .RD_CYC(RD), .WZ_CYC(WZ), .WR_OE_LOW(1'b1)
  ) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // memory model: drives while selected and output-enabled, and keeps
  // driving for WZ cycles after the write strobe falls
  assign mem_drv    = !sram_ce_n && !sram_oe_n && (sram_we_n || we_low_cnt < WZ);
  assign sram_dq_in = sram_dq_oe ? sram_dq_out : (mem_drv ? mem[sram_addr] : '0);

  function automatic logic [DW-1:0] pat1(input int a);
    return DW'(a * 37 + 5);
  endfunction
  function automatic logic [DW-1:0] pat2(input int a);
    return DW'(a * 3) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bus monitor, sampled away from the active edge
  logic          p_ce_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  int  addr_run = 0, setup_run = 0, hold_run = 0;
  bit  gap_seen = 1'b1, wr_hold = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sram_dq_oe && mem_drv) chk(1'b0, "R6 contention", 1, 0);
      if (!sram_we_n && sram_ce_n) chk(1'b0, "R9 strobe without select", 1, 0);
      if (!sram_we_n && sram_oe_n) chk(1'b0, "R6 oe low in write", 1, 0);
      addr_run = (sram_addr == p_addr) ? addr_run + 1 : 1;
      if (!sram_ce_n && !p_ce_n && sram_addr != p_addr)
        chk(1'b0, "R3 address moved", int'(sram_addr), int'(p_addr));
      if (!sram_ce_n && p_ce_n) begin
        chk(addr_run >= ASU + 1, "R3 address setup", addr_run, ASU + 1);
        chk(gap_seen, "R8 idle gap", 0, 1);
        gap_seen = 1'b0;
      end
      if (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe) gap_seen = 1'b1;
      if (!sram_we_n) begin
        if (sram_dq_oe && p_dq_oe && !p_we_n && sram_dq_out == p_dq) setup_run++;
        else if (sram_dq_oe) setup_run = 1;
      end
      if (sram_we_n && !p_we_n) begin
        chk(we_low_cnt == WLEN, "R5 strobe width", we_low_cnt, WLEN);
        chk(sram_ce_n, "R5 select rises with strobe", 0, 1);
        chk(setup_run >= DSU, "R7 data setup", setup_run, DSU);
        if (p_dq_oe) mem[sram_addr] = p_dq;
        wr_hold  = 1'b1;
        hold_run = 0;
      end
      if (wr_hold) begin
        if (sram_dq_oe && sram_dq_out == p_dq) hold_run++;
        else begin
          chk(hold_run >= DH, "R7 data hold", hold_run, DH);
          wr_hold = 1'b0;
        end
      end
      if (!sram_we_n) we_low_cnt++;
      else begin
        we_low_cnt = 0;
        setup_run  = 0;
      end
    end
    p_ce_n  = sram_ce_n;
    p_we_n  = sram_we_n;
    p_dq_oe = sram_dq_oe;
    p_addr  = sram_addr;
    p_dq    = sram_dq_out;
  end

  task automatic do_write(input int a, input logic [DW-1:0] d);
    int k;
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!req_ready) begin @(negedge clk); k++; end
    // R2
    chk(k == ASU + WLEN + DH + 2, "R2 write busy time", k, ASU + WLEN + DH + 2);
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] exp);
    int k, vk, pulses;
    logic [DW-1:0] got;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; vk = 0; pulses = 0; got = '0;
    forever begin
      if (rd_valid) begin pulses++; vk = k; got = rd_data; end
      if (req_ready) break;
      @(negedge clk); k++;
    end
    // R4
    chk(vk == ASU + RD + 1, "R4 read latency", vk, ASU + RD + 1);
    chk(pulses == 1, "R4 single pulse", pulses, 1);
    chk(got == exp, "R4 R7 read data", int'(got), int'(exp));
    // R2
    chk(k == ASU + RD + 2, "R2 read busy time", k, ASU + RD + 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 8'hEE;
    repeat (4) @(negedge clk);
    // R1: during reset
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 strobes in reset",
        {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
    chk(req_ready && !rd_valid, "R1 handshake in reset", {req_ready, rd_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready,
        "R1 after reset", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready}, 5'b11101);
    for (int a = 0; a < NW; a++) do_write(a, pat1(a));
    for (int a = 0; a < NW; a++) do_read(a, pat1(a));
    for (int a = NW - 1; a >= 0; a--) do_write(a, pat2(a));
    for (int a = 0; a < NW; a++) do_read((a * 7) % NW, pat2((a * 7) % NW));
    for (int a = 0; a < 8; a++) begin
      do_write(a * 5, pat1(a) ^ 8'hFF);
      do_read(a * 5, pat1(a) ^ 8'hFF);
    end
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

endmodule